// File: doc/BRIEF.md
# Byte-Level I2C Master with Status-Code Handshake

This controller runs one side of an I2C bus as a master, one bus event at a time. Software loads a data register and pulses a control write that can request a START, request a STOP, set the acknowledge policy for received bytes and clear the event flag. After each bus event the controller raises the event flag and posts an 8-bit status code. It then holds SCL low until software clears the flag. Software reads the code and chooses the next action. It can send another byte, read one, issue a repeated START, issue a STOP, or issue a STOP followed by a fresh START.

The byte sent right after any START is an address byte, taken from the data register; its bit 0 selects read (1) or write (0). The following bytes are written or read according to that bit. SCL and SDA are open-drain: the block drives only `scl_oe`/`sda_oe`, meaning "pull the line low", and samples the wired lines on `scl_in`/`sda_in`. The block watches START and STOP conditions from any master to know when the bus is busy. It gives up the bus when another master wins arbitration.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the flag is 0, the status is F8h, both line drivers are released and the bus is seen as free.
- R2: A requested START on a free bus ends with the flag set and status 08h. While the flag stays set after any event other than arbitration loss, SCL is held low.
- R3: The address byte is the data register with bit 0 as read(1)/write(0). When the flag is set again, the status is 18h for a write address that was acknowledged, 20h for a write address that was not, 40h for a read address that was acknowledged and 48h for a read address that was not.
- R4: A data byte sent in write mode is transferred MSB first and reports 28h when the slave acknowledges it, or 30h when it does not.
- R5: In read mode each received byte (MSB first) appears on `dat_rdata`. The master returns ACK if the last control write had `ctl_ack`=1 (status 50h) and NACK otherwise (status 58h).
- R6: A START requested while the bus is already held by this master gives status 10h.
- R7: A STOP request sends STOP and then clears `stp_pend` by itself. The block then goes idle with the flag clear, status F8h and both lines released.
- R8: Requesting START and STOP together sends STOP, then START, and reports 08h.
- R9: If SDA reads low during a bit where the master releases SDA in an address or data byte, the block releases both lines at once. It then sets the flag with status 38h.
- R10: After status 38h, clearing the flag alone returns the block to idle with status F8h and no START. Clearing it with STA requested makes the block wait until a STOP from another master frees the bus, and then issue a START.
- R11: Each SCL quarter period is `clk_div`+1 clock cycles, so SCL is released for 2×(`clk_div`+1) cycles per bit.
- R12: The flag is cleared only by a control write with `ctl_clr`=1. The status does not change while the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Clock cycles per SCL quarter period, minus one |
| dat_we | input | 1 | Write strobe for the data register |
| dat_wdata | input | 8 | Value loaded into the data register |
| ctl_we | input | 1 | Control write strobe |
| ctl_sta | input | 1 | With ctl_we: request START |
| ctl_stp | input | 1 | With ctl_we: request STOP |
| ctl_ack | input | 1 | With ctl_we: ACK(1)/NACK(0) policy for received bytes |
| ctl_clr | input | 1 | With ctl_we: clear the event flag |
| dat_rdata | output | 8 | Data register (last received byte after a read) |
| status | output | 8 | Status code of the last event |
| flag | output | 1 | Event flag |
| sta_pend | output | 1 | START request pending |
| stp_pend | output | 1 | STOP request pending |
| bus_busy | output | 1 | Bus busy as seen from START/STOP conditions |
| scl_in | input | 1 | Wired SCL line level |
| sda_in | input | 1 | Wired SDA line level |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The bench builds the block with DIV_W=4 and runs most transfers with `clk_div`=1. Bytes are therefore short, and many random write and read bytes fit in a short run. One address phase runs with `clk_div`=3 so the SCL high time can be measured at two divider settings. A second bus master is modelled by a separate SDA pull-down. That pull-down wins arbitration on a high bit and holds the bus busy until it is released. This makes both the give-up path and the wait-for-free-bus path after status 38h observable.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             dat_we,
  input  logic [7:0]       dat_wdata,
  input  logic             ctl_we,
  input  logic             ctl_sta,
  input  logic             ctl_stp,
  input  logic             ctl_ack,
  input  logic             ctl_clr,
  output logic [7:0]       dat_rdata,
  output logic [7:0]       status,
  output logic             flag,
  output logic             sta_pend,
  output logic             stp_pend,
  output logic             bus_busy,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_XFER, S_STOP, S_WAIT, S_LOST} state_t;

  state_t           st;
  logic [DIV_W-1:0] cnt;
  logic [1:0]       ph;
  logic [3:0]       bitn;
  logic [7:0]       sh, dat;
  logic             samp, rd_mode, addr_nxt, rx_now, is_addr, started, ack_en;
  logic             scl_q, sda_q;

  wire active = (st == S_START) || (st == S_XFER) || (st == S_STOP);
  wire tick   = active && (cnt == clk_div);

  assign dat_rdata = dat;

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = ph[1];
      end
      S_XFER: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = (bitn == 4'd8) ? (rx_now & ack_en) : (!rx_now & !sh[7]);
      end
      S_STOP: begin
        scl_oe = (ph == 2'd0);
        sda_oe = !ph[1];
      end
      S_WAIT:  scl_oe = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (!active || tick) cnt <= '0;
    else cnt <= cnt + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; bus_busy <= 1'b0;
    end else begin
      scl_q <= scl_in; sda_q <= sda_in;
      if (scl_in && scl_q && sda_q && !sda_in) bus_busy <= 1'b1;
      else if (scl_in && scl_q && !sda_q && sda_in) bus_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 2'd0; bitn <= 4'd0; sh <= 8'h00; dat <= 8'h00;
      samp <= 1'b1; rd_mode <= 1'b0; addr_nxt <= 1'b0; rx_now <= 1'b0;
      is_addr <= 1'b0; started <= 1'b0; ack_en <= 1'b0;
      sta_pend <= 1'b0; stp_pend <= 1'b0; flag <= 1'b0; status <= 8'hF8;
    end else begin
      if (dat_we) dat <= dat_wdata;
      if (ctl_we) begin
        sta_pend <= sta_pend | ctl_sta;
        stp_pend <= stp_pend | ctl_stp;
        ack_en   <= ctl_ack;
        if (ctl_clr) flag <= 1'b0;
      end
      if (tick) ph <= ph + 2'd1;
      case (st)
        S_IDLE: begin
          ph <= 2'd0;
          if (stp_pend) stp_pend <= 1'b0;
          if (sta_pend && !bus_busy) st <= S_START;
        end
        S_START: if (tick && ph == 2'd3) begin
          st <= S_WAIT; flag <= 1'b1;
          status <= started ? 8'h10 : 8'h08;
          started <= 1'b1; sta_pend <= 1'b0; addr_nxt <= 1'b1;
        end
        S_STOP: if (tick && ph == 2'd3) begin
          stp_pend <= 1'b0; started <= 1'b0;
          if (sta_pend) st <= S_START;
          else begin st <= S_IDLE; status <= 8'hF8; end
        end
        S_XFER: if (tick) begin
          if (ph == 2'd2) begin
            samp <= sda_in;
            if (bitn != 4'd8 && !rx_now && sh[7] && !sda_in) begin
              st <= S_LOST; flag <= 1'b1; status <= 8'h38; started <= 1'b0;
            end
          end else if (ph == 2'd3) begin
            if (bitn != 4'd8) begin
              sh <= {sh[6:0], samp};
              bitn <= bitn + 4'd1;
            end else begin
              st <= S_WAIT; flag <= 1'b1;
              if (is_addr) status <= rd_mode ? (samp ? 8'h48 : 8'h40) : (samp ? 8'h20 : 8'h18);
              else if (rx_now) begin
                dat <= sh;
                status <= ack_en ? 8'h50 : 8'h58;
              end else status <= samp ? 8'h30 : 8'h28;
            end
          end
        end
        S_WAIT: begin
          ph <= 2'd0;
          if (!flag) begin
            if (stp_pend) st <= S_STOP;
            else if (sta_pend) st <= S_START;
            else begin
              st <= S_XFER; bitn <= 4'd0; sh <= dat;
              is_addr <= addr_nxt; rx_now <= !addr_nxt && rd_mode;
              if (addr_nxt) rd_mode <= dat[0];
              addr_nxt <= 1'b0;
            end
          end
        end
        default: begin
          ph <= 2'd0;
          if (!flag) begin st <= S_IDLE; status <= 8'hF8; end
        end
      endcase
    end
  end

  assert_flag_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(ctl_we && ctl_clr)) |=> (flag && $stable(status)));

  assert_stall_scl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && status != 8'h38) |-> scl_oe);

  assert_stop_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && tick && ph == 2'd3 && !(ctl_we && ctl_stp)) |=> !stp_pend);

  assert_lost_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && status == 8'h38) |-> (!scl_oe && !sda_oe));

  assert_wait_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && bus_busy) |=> (st != S_START));

  assert_code_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (status[2:0] == 3'b000 && status != 8'hF8));

endmodule

// File: tb/sim_i2c_cmd_master.sv
module sim_i2c_cmd_master;
  localparam int DW = 4;
  localparam logic [6:0] SADDR = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] clk_div = 4'd1;
  logic dat_we = 0, ctl_we = 0, ctl_sta = 0, ctl_stp = 0, ctl_ack = 0, ctl_clr = 0;
  logic [7:0] dat_wdata = 0;
  logic [7:0] dat_rdata, status;
  logic flag, sta_pend, stp_pend, bus_busy, scl_oe, sda_oe;
  logic jam = 1'b0;
  logic sl_sda;
  wire scl = !scl_oe;
  wire sda = !(sda_oe || sl_sda || jam);

  always #5 clk = ~clk;

  i2c_cmd_master #(.DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .ctl_we(ctl_we), .ctl_sta(ctl_sta), .ctl_stp(ctl_stp), .ctl_ack(ctl_ack), .ctl_clr(ctl_clr),
    .dat_rdata(dat_rdata), .status(status), .flag(flag),
    .sta_pend(sta_pend), .stp_pend(stp_pend), .bus_busy(bus_busy),
    .scl_in(scl), .sda_in(sda), .scl_oe(scl_oe), .sda_oe(sda_oe));

  // behavioural slave at SADDR
  logic [7:0] sl_sh, sl_cur, sl_got;
  logic [3:0] sl_bc;
  logic [1:0] sl_mode;
  logic sl_inack, sl_rw, sl_mack, sclp, sdap;
  logic sl_nack = 1'b0;
  logic [7:0] txq [0:7];
  int sl_ti, sl_stops;

  always @(posedge clk) begin
    if (!rst_n) begin
      sl_sda <= 0; sl_sh <= 0; sl_cur <= 0; sl_got <= 0; sl_bc <= 0; sl_mode <= 0;
      sl_inack <= 0; sl_rw <= 0; sl_mack <= 0; sclp <= 1; sdap <= 1; sl_ti <= 0; sl_stops <= 0;
    end else begin
      sclp <= scl; sdap <= sda;
      if (scl && sclp && sdap && !sda) begin
        sl_mode <= 2'd1; sl_bc <= 0; sl_inack <= 0; sl_sda <= 0; sl_ti <= 0;
      end else if (scl && sclp && !sdap && sda) begin
        sl_mode <= 2'd0; sl_stops <= sl_stops + 1; sl_sda <= 0;
      end else if (scl && !sclp) begin
        if (!sl_inack) begin sl_sh <= {sl_sh[6:0], sda}; sl_bc <= sl_bc + 4'd1; end
        else sl_mack <= !sda;
      end else if (!scl && sclp && sl_mode != 2'd0) begin
        if (!sl_inack && sl_bc == 4'd8) begin
          sl_inack <= 1;
          case (sl_mode)
            2'd1: if (sl_sh[7:1] == SADDR) begin sl_sda <= 1; sl_rw <= sl_sh[0]; end
                  else begin sl_mode <= 2'd0; sl_sda <= 0; end
            2'd2: begin sl_got <= sl_sh; sl_sda <= !sl_nack; end
            default: sl_sda <= 0;
          endcase
        end else if (sl_inack) begin
          sl_inack <= 0; sl_bc <= 0; sl_sda <= 0;
          if (sl_mode == 2'd1) begin
            sl_mode <= sl_rw ? 2'd3 : 2'd2;
            if (sl_rw) begin sl_sda <= !txq[sl_ti][7]; sl_cur <= txq[sl_ti]; sl_ti <= sl_ti + 1; end
          end else if (sl_mode == 2'd3) begin
            if (sl_mack) begin sl_sda <= !txq[sl_ti][7]; sl_cur <= txq[sl_ti]; sl_ti <= sl_ti + 1; end
            else sl_mode <= 2'd0;
          end
        end else if (sl_mode == 2'd3 && sl_bc != 4'd0) sl_sda <= !sl_cur[4'd7 - sl_bc[2:0]];
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_addr(input bit rd, input bit ack);
    return rd ? (ack ? 8'h40 : 8'h48) : (ack ? 8'h18 : 8'h20);
  endfunction
  function automatic logic [7:0] exp_tx(input bit ack);  return ack ? 8'h28 : 8'h30; endfunction
  function automatic logic [7:0] exp_rx(input bit ack);  return ack ? 8'h50 : 8'h58; endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_dat(input logic [7:0] b);
    @(negedge clk); dat_we = 1; dat_wdata = b; @(negedge clk); dat_we = 0;
  endtask
  task automatic wr_ctl(input bit sta, input bit stp, input bit ack, input bit clr);
    @(negedge clk); ctl_we = 1; ctl_sta = sta; ctl_stp = stp; ctl_ack = ack; ctl_clr = clr;
    @(negedge clk); ctl_we = 0; ctl_sta = 0; ctl_stp = 0; ctl_clr = 0;
  endtask
  task automatic wait_flag(input string req);
    int t = 0;
    while (!flag && t < 4000) begin @(negedge clk); t++; end
    chk(flag, req, 0, 1);
  endtask
  task automatic clr_measure(input string req, input int exp_hi);
    int hi = 0;
    wr_ctl(0, 0, 0, 1);
    while (!scl) @(negedge clk);
    while (scl) begin hi++; @(negedge clk); end
    chk(hi == exp_hi, req, hi, exp_hi);
  endtask
  task automatic do_stop(input string req);
    int t = 0;
    wr_ctl(0, 1, 0, 1);
    while (stp_pend && t < 2000) begin @(negedge clk); t++; end
    cyc(3);
    chk(!stp_pend && !flag && status == 8'hF8 && !scl_oe && !sda_oe && !bus_busy, req, status, 8'hF8);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] b;
    bit a;
    int st0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) txq[i] = 8'($urandom);
    cyc(4); rst_n = 1; cyc(2);
    chk(!flag && status == 8'hF8 && !scl_oe && !sda_oe && !bus_busy, "R1", status, 8'hF8);

    wr_ctl(1, 0, 0, 0);
    wait_flag("R2");
    chk(status == 8'h08, "R2", status, 8'h08);
    cyc(50);
    chk(flag && scl_oe && status == 8'h08, "R2 stall / R12", {flag, scl_oe}, 3);

    wr_dat({SADDR, 1'b0});
    clr_measure("R11 div1", 4);
    wait_flag("R3");
    chk(status == exp_addr(0, 1), "R3 write addr ack", status, exp_addr(0, 1));

    for (int i = 0; i < 6; i++) begin
      b = 8'($urandom); a = ($urandom % 3) != 0;
      sl_nack = !a;
      wr_dat(b); wr_ctl(0, 0, 0, 1);
      wait_flag("R4");
      chk(status == exp_tx(a), "R4 status", status, exp_tx(a));
      chk(sl_got == b, "R4 byte", sl_got, b);
    end
    sl_nack = 0;

    wr_ctl(1, 0, 0, 1);
    wait_flag("R6");
    chk(status == 8'h10, "R6", status, 8'h10);
    wr_dat({SADDR, 1'b1}); wr_ctl(0, 0, 0, 1);
    wait_flag("R3");
    chk(status == exp_addr(1, 1), "R3 read addr ack", status, exp_addr(1, 1));

    for (int i = 0; i < 5; i++) begin
      a = (i != 4);
      wr_ctl(0, 0, a, 1);
      wait_flag("R5");
      chk(status == exp_rx(a), "R5 status", status, exp_rx(a));
      chk(dat_rdata == txq[i], "R5 byte", dat_rdata, txq[i]);
    end
    do_stop("R7");

    wr_ctl(1, 0, 0, 0); wait_flag("R2");
    wr_dat({7'h11, 1'b0}); wr_ctl(0, 0, 0, 1); wait_flag("R3");
    chk(status == exp_addr(0, 0), "R3 write addr nack", status, exp_addr(0, 0));
    st0 = sl_stops;
    wr_ctl(1, 1, 0, 1); wait_flag("R8");
    chk(status == 8'h08 && sl_stops == st0 + 1, "R8", status, 8'h08);
    wr_dat({7'h11, 1'b1}); wr_ctl(0, 0, 0, 1); wait_flag("R3");
    chk(status == exp_addr(1, 0), "R3 read addr nack", status, exp_addr(1, 0));
    do_stop("R7");

    clk_div = 4'd3;
    wr_ctl(1, 0, 0, 0); wait_flag("R2");
    wr_dat({SADDR, 1'b0});
    clr_measure("R11 div3", 8);
    wait_flag("R3");
    chk(status == 8'h18, "R11 addr", status, 8'h18);
    do_stop("R7");
    clk_div = 4'd1;

    wr_ctl(1, 0, 0, 0); wait_flag("R2");
    wr_dat({SADDR, 1'b0}); wr_ctl(0, 0, 0, 1); wait_flag("R3");
    jam = 1; wr_dat(8'hFF); wr_ctl(0, 0, 0, 1);
    wait_flag("R9");
    chk(status == 8'h38 && !scl_oe && !sda_oe && bus_busy, "R9", status, 8'h38);
    wr_ctl(1, 0, 0, 1); cyc(40);
    chk(!flag && !scl_oe && !sda_oe && sta_pend, "R10 waits for free bus", flag, 0);
    jam = 0;
    wait_flag("R10");
    chk(status == 8'h08, "R10 start after free", status, 8'h08);
    do_stop("R7");

    wr_ctl(1, 0, 0, 0); wait_flag("R2");
    wr_dat({SADDR, 1'b0}); wr_ctl(0, 0, 0, 1); wait_flag("R3");
    jam = 1; wr_dat(8'hC3); wr_ctl(0, 0, 0, 1);
    wait_flag("R9");
    chk(status == 8'h38, "R9 second", status, 8'h38);
    wr_ctl(0, 0, 0, 1); cyc(20);
    chk(!flag && status == 8'hF8 && !sta_pend, "R10 clear alone", status, 8'hF8);
    jam = 0; cyc(200);
    chk(!flag && !scl_oe && !sda_oe && !bus_busy, "R10 no start", flag, 0);

    report();
  end
endmodule